// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus after a slave was interrupted in the middle of a transfer and is left holding the data line low. One pulse on `start_i` begins a recovery run. The block first leaves both lines released. It then pulls the clock line low and lets it go a fixed number of times, nine by default. After each release it waits until the clock line reads high, so a slave that stretches the clock is tolerated, and it samples the data line. All nine clocks are always issued, even when the data line has already been seen high.

If the data line was high in any sample, the bus is taken to be back in step. The block then checks that both lines are at rest, and raises a warning if either reads low. Next it forms a START by pulling the data line low and a STOP by releasing it, and the clock line stays released through both, because some slaves lock up if the clock falls between the two. It then waits out the bus-free time. If the data line stayed low through every sample, the run ends with a failure and the block does not attempt a START or STOP. Both lines are open-drain: an output enable of 1 pulls the line low. Every delay is given in microseconds and scaled by a clock-per-microsecond parameter.

Top module: `busrec_seq`

## Requirements
- R1: When the block is idle, after reset or after a run, `busy_o` is 0 and both `scl_oe_o` and `sda_oe_o` are 0, so both lines are released.
- R2: Every run issues exactly PULSES clock pulses, 9 by default. A pulse is a rising edge of `scl_oe_o`. The count does not change with the sampled data values.
- R3: Each clock pull-low keeps `scl_oe_o` at 1 for exactly HALF_US*CLK_PER_US cycles.
- R4: After a release, the next clock pull does not begin until the clock line has read high for at least HALF_US*CLK_PER_US cycles, so a stretched clock lengthens the run.
- R5: If the clock line stays low for TIMEOUT_US*CLK_PER_US cycles after a release, `stuck_o` is 1 at the end of the run, and the run still issues all of its pulses.
- R6: If the data line read low at every sample taken after a clock release, `fail_o` is 1 at the end of the run and `sda_oe_o` never becomes 1 during that run.
- R7: If any sample read the data line high, `fail_o` is 0 and `sda_oe_o` is 1 for exactly one window of GUARD_US*CLK_PER_US cycles. `scl_oe_o` is 0 whenever `sda_oe_o` is 1 or changes.
- R8: `warn_o` is 1 at the end of a successful run if the clock line or the data line read low at the rest check that follows the last pulse. Otherwise it is 0.
- R9: `done_o` is a one-cycle pulse that ends each run. When a START/STOP was issued, at least BUF_US*CLK_PER_US cycles pass from the release of `sda_oe_o` to `done_o`. `fail_o`, `warn_o` and `stuck_o` hold their values until the next run starts.
- R10: A `start_i` pulse that arrives while `busy_o` is 1 is ignored: no extra pulses are issued and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a recovery run; taken only while idle |
| scl_i | input | 1 | Level read back from the clock line |
| sda_i | input | 1 | Level read back from the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Data line never seen high; bus wedged |
| warn_o | output | 1 | Lines not both high at the rest check |
| stuck_o | output | 1 | A clock release timed out |

## Verification
The bench builds the block with CLK_PER_US=4, HALF_US=2, GUARD_US=1, BUF_US=60 and TIMEOUT_US=20. A pull-low then lasts 8 cycles and the timeout 80 cycles, so a bench slave can stretch the clock either below or beyond the timeout within a short run. With these values a clock jammed low, a slave that frees the data line only on the ninth clock, and a data line that falls again before the rest check all take a few hundred cycles each. PULSES stays at 9, which keeps the sample-by-sample data patterns at 10 bits.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REL,
        ST_LOW,
        ST_RISE,
        ST_HIGH,
        ST_CHECK,
        ST_SETUP,
        ST_PULL,
        ST_BUF,
        ST_DONE
    } rec_state_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
    parameter int BITS   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [BITS-1:0] async_i,
    output logic [BITS-1:0] sync_o
);
    for (genvar b = 0; b < BITS; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/busrec_timer.sv
module busrec_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
    import busrec_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int PULSES     = 9,
    parameter int HALF_US    = 5,
    parameter int GUARD_US   = 1,
    parameter int BUF_US     = 60,
    parameter int TIMEOUT_US = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic busy_o,
    output logic done_o,
    output logic fail_o,
    output logic warn_o,
    output logic stuck_o
);
    localparam int HALF_CYC  = HALF_US * CLK_PER_US;
    localparam int GUARD_CYC = GUARD_US * CLK_PER_US;
    localparam int BUF_CYC   = BUF_US * CLK_PER_US;
    localparam int TOUT_CYC  = TIMEOUT_US * CLK_PER_US;
    localparam int MAXC      = int'(max4(HALF_CYC, GUARD_CYC, BUF_CYC, TOUT_CYC));
    localparam int TW        = $clog2(MAXC + 1);
    localparam int CW        = $clog2(PULSES + 1);

    localparam logic [TW-1:0] HALF_LD  = TW'(HALF_CYC - 1);
    localparam logic [TW-1:0] GUARD_LD = TW'(GUARD_CYC - 1);
    localparam logic [TW-1:0] BUF_LD   = TW'(BUF_CYC - 1);
    localparam logic [TW-1:0] TOUT_LD  = TW'(TOUT_CYC - 1);
    localparam logic [CW-1:0] LAST_PULSE = CW'(PULSES - 1);

    typedef struct packed {
        rec_state_e    st;
        logic [CW-1:0] cnt;
        logic          was_high;
        logic          stuck;
        logic          warn;
        logic          fail;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic [1:0]    lines_s;
    logic          scl_s, sda_s;

    busrec_sync #(.BITS(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    busrec_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ctl_q.st)
            ST_IDLE: if (start_i) begin
                ctl_d.st       = ST_REL;
                ctl_d.cnt      = '0;
                ctl_d.was_high = 1'b0;
                ctl_d.stuck    = 1'b0;
                ctl_d.warn     = 1'b0;
                ctl_d.fail     = 1'b0;
                tmr_load       = 1'b1;
                tmr_val        = HALF_LD;
            end
            ST_REL: if (tmr_zero) begin
                ctl_d.st = ST_LOW;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
            end
            ST_LOW: if (tmr_zero) begin
                ctl_d.st = ST_RISE;
                tmr_load = 1'b1;
                tmr_val  = TOUT_LD;
            end
            ST_RISE: if (scl_s || tmr_zero) begin
                if (!scl_s) ctl_d.stuck = 1'b1;
                ctl_d.st = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = HALF_LD;
            end
            ST_HIGH: if (tmr_zero) begin
                ctl_d.was_high = ctl_q.was_high | sda_s;
                ctl_d.cnt      = ctl_q.cnt + 1'b1;
                if (ctl_q.cnt == LAST_PULSE) begin
                    ctl_d.st = ST_CHECK;
                end else begin
                    ctl_d.st = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                end
            end
            ST_CHECK: begin
                if (ctl_q.was_high) begin
                    ctl_d.warn = !(scl_s && sda_s);
                    ctl_d.st   = ST_SETUP;
                    tmr_load   = 1'b1;
                    tmr_val    = GUARD_LD;
                end else begin
                    ctl_d.fail = 1'b1;
                    ctl_d.st   = ST_DONE;
                end
            end
            ST_SETUP: if (tmr_zero) begin
                ctl_d.st = ST_PULL;
                tmr_load = 1'b1;
                tmr_val  = GUARD_LD;
            end
            ST_PULL: if (tmr_zero) begin
                ctl_d.st = ST_BUF;
                tmr_load = 1'b1;
                tmr_val  = BUF_LD;
            end
            ST_BUF: if (tmr_zero) ctl_d.st = ST_DONE;
            ST_DONE: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, cnt: '0, default: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign scl_oe_o = (ctl_q.st == ST_LOW);
    assign sda_oe_o = (ctl_q.st == ST_PULL);
    assign busy_o   = (ctl_q.st != ST_IDLE);
    assign done_o   = (ctl_q.st == ST_DONE);
    assign fail_o   = ctl_q.fail;
    assign warn_o   = ctl_q.warn;
    assign stuck_o  = ctl_q.stuck;
endmodule

// File: rtl/busrec_chk.sv
module busrec_chk #(
    parameter int PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic fail
);
    logic [7:0] pulse_cnt;
    logic       scl_oe_prev;
    logic       pulled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_cnt   <= '0;
            scl_oe_prev <= 1'b0;
            pulled      <= 1'b0;
        end else begin
            scl_oe_prev <= scl_oe;
            if (!busy) begin
                pulse_cnt <= '0;
                pulled    <= 1'b0;
            end else begin
                if (scl_oe && !scl_oe_prev) pulse_cnt <= pulse_cnt + 1'b1;
                if (sda_oe) pulled <= 1'b1;
            end
        end
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    a_r2_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pulse_cnt == 8'(PULSES)));

    a_r6_fail_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> !pulled);

    a_r7_sda_moves_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe) || sda_oe) |-> !scl_oe);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind busrec_seq busrec_chk #(.PULSES(PULSES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_oe (scl_oe_o),
    .sda_oe (sda_oe_o),
    .busy   (busy_o),
    .done   (done_o),
    .fail   (fail_o)
);

// File: tb/sim_busrec_seq.sv
module sim_busrec_seq;
    localparam int CPU   = 4;
    localparam int HALF  = 2 * CPU;
    localparam int GUARD = 1 * CPU;
    localparam int BUFC  = 60 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic scl_oe, sda_oe, busy, done, fail, warn, stuck;
    logic scl_line, sda_line;

    logic [9:0] rel_q = '1;
    int  stretch = 0;
    bit  jam = 1'b0;
    bit  chk_rise = 1'b1;
    int  since_rel = 1000;
    int  rises = 0;

    int checks = 0, failures = 0, cycles = 0;

    int pulses, low_run, low_bad, hi_cnt, rise_bad;
    int sda_pulses, sda_run, sda_len, scl_bad, gap, gap_rec, done_cnt;
    bit gap_on;
    logic r_fail, r_warn, r_stuck;
    logic p_scl_oe = 1'b0, p_sda_oe = 1'b0, p_scl_line = 1'b1;

    always #4 clk = ~clk;

    assign scl_line = !scl_oe && !jam && !(since_rel < stretch);
    assign sda_line = !sda_oe && rel_q[rises];

    busrec_seq #(.CLK_PER_US(CPU), .PULSES(9), .HALF_US(2), .GUARD_US(1),
                 .BUF_US(60), .TIMEOUT_US(20)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
        .fail_o(fail), .warn_o(warn), .stuck_o(stuck)
    );

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (scl_line && !p_scl_line && rises < 9) rises = rises + 1;
        if (scl_oe && !p_scl_oe) begin
            pulses = pulses + 1;
            if (chk_rise && hi_cnt < HALF) rise_bad = rise_bad + 1;
            low_run = 0;
        end
        if (scl_oe) low_run = low_run + 1;
        if (!scl_oe && p_scl_oe && low_run != HALF) low_bad = low_bad + 1;
        if (scl_line) hi_cnt = hi_cnt + 1; else hi_cnt = 0;
        if (scl_oe) since_rel = 0; else if (since_rel < 1000) since_rel = since_rel + 1;
        if (sda_oe && !p_sda_oe) begin sda_pulses = sda_pulses + 1; sda_run = 0; end
        if (sda_oe) begin
            sda_run = sda_run + 1;
            if (scl_oe) scl_bad = scl_bad + 1;
        end
        if (!sda_oe && p_sda_oe) begin sda_len = sda_run; gap = 0; gap_on = 1'b1; end
        if (gap_on && !done) gap = gap + 1;
        if (done) begin
            done_cnt = done_cnt + 1;
            r_fail = fail; r_warn = warn; r_stuck = stuck;
            if (gap_on) begin gap_rec = gap; gap_on = 1'b0; end
        end
        p_scl_oe = scl_oe; p_sda_oe = sda_oe; p_scl_line = scl_line;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic run(input logic [9:0] rel, input int str, input bit jm,
                       input bit rises_ok, input bit poke);
        bit e_high, e_warn, e_fail, e_stuck;
        int waited;
        rel_q = rel; stretch = str; jam = jm; chk_rise = rises_ok; rises = 0;
        pulses = 0; low_bad = 0; rise_bad = 0; sda_pulses = 0; sda_len = 0;
        scl_bad = 0; gap_rec = -1; gap_on = 1'b0; done_cnt = 0; hi_cnt = HALF;
        e_high  = rises_ok ? (|rel[9:1]) : rel[0];
        e_warn  = e_high && !(rises_ok && rel[9]);
        e_fail  = !e_high;
        e_stuck = !rises_ok;
        start = 1'b1; step(); start = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            step(); waited++;
            if (poke && waited == 50) begin start = 1'b1; step(); start = 1'b0; end
        end
        if (waited >= 20000) chk(0, "R9 done timeout", waited, 0);
        repeat (6) step();
        chk(pulses == 9, "R2 pulse count", pulses, 9);
        chk(low_bad == 0, "R3 low width", low_bad, 0);
        if (rises_ok) chk(rise_bad == 0, "R4 wait for high", rise_bad, 0);
        chk(r_stuck == e_stuck, "R5 stuck", r_stuck, e_stuck);
        chk(r_fail == e_fail, "R6 fail", r_fail, e_fail);
        chk(sda_pulses == (e_high ? 1 : 0), "R7 sda pulls", sda_pulses, e_high);
        if (e_high) chk(sda_len == GUARD, "R7 sda width", sda_len, GUARD);
        chk(scl_bad == 0, "R7 scl during sda", scl_bad, 0);
        chk(r_warn == e_warn, "R8 warn", r_warn, e_warn);
        chk(done_cnt == 1, "R9 done pulse", done_cnt, 1);
        if (e_high) chk(gap_rec >= BUFC, "R9 bus free gap", gap_rec, BUFC);
        chk(fail == e_fail && warn == e_warn, "R9 status held", {fail, warn}, {e_fail, e_warn});
        chk(!busy && !scl_oe && !sda_oe, "R1 idle after run", {busy, scl_oe, sda_oe}, 0);
        if (poke) chk(!busy && pulses == 9, "R10 start ignored while busy", pulses, 9);
    endtask

    initial begin
        #150000000;
        failures = failures + 1;
        checks = checks + 1;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk(!busy && !scl_oe && !sda_oe && !done, "R1 reset state",
            {busy, scl_oe, sda_oe, done}, 0);
        chk(!fail && !warn && !stuck, "R1 reset status", {fail, warn, stuck}, 0);
        run(10'b0, 0, 1'b0, 1'b1, 1'b0);
        run(10'b00_0000_0001, 0, 1'b0, 1'b1, 1'b0);
        run(10'b10_0000_0000, 0, 1'b0, 1'b1, 1'b0);
        run(10'b00_0000_0010, 3, 1'b0, 1'b1, 1'b0);
        run(10'b0, 0, 1'b1, 1'b0, 1'b0);
        jam = 1'b0; repeat (4) step();
        run(10'b11_1111_1111, 100, 1'b0, 1'b0, 1'b0);
        stretch = 0; repeat (4) step();
        for (int i = 0; i < 10; i++) begin
            run(10'($urandom), int'($urandom % 30), 1'b0, 1'b1, i == 3);
        end
        finish_run();
    end
endmodule